// File: doc/BRIEF.md
# Preset Event Counter with Interrupt Status

This block counts single-cycle event pulses in a 16-bit two's complement accumulator and keeps a 16-bit status word that software reads. It works in one of two modes, chosen when it is configured. In up mode only up pulses count, and the block latches a hit flag when the count steps onto the high preset. In bidirectional mode, up and down pulses move the count in opposite directions. In this mode the block latches overflow and underflow wraps and shows two live compare flags against the high and low presets.

Counter events raise an interrupt request, but only while the interrupt-enable bit is set. A request that arrives while another is still pending marks the interrupt as lost. When the host acknowledges the request, the cause of the serviced request is loaded into a one-hot cause field, and loading it clears the other cause bits.

The host controls the block through plain single-cycle strobes: configure, reset/reload, acknowledge, one clear per latched flag, and snapshot. No port carries a data stream, so none of them needs valid/ready back-pressure. Every strobe is sampled on the rising clock edge.

Top module: `preset_event_counter`

## Requirements
- R1: After `rst_n` is low, `status`, `acc` and `snap_acc` are all zero, the mode is up, and `irq` is low. Status bit 0 always reads 0.
- R2: On a `cfg_stb` cycle, the mode is loaded from `cfg_bidir` (1 = bidirectional) and bit 1 (interrupt enable) is set. Bits 3 to 7, 14 and 15 read 0 in the next cycle. Bits 13, 12, 11 and 2 keep their value.
- R3: A pulse on `up_pulse` with `up_en` high adds 1 to `acc`. In bidirectional mode, a pulse on `dn_pulse` with `dn_en` high subtracts 1. Up and down together leave `acc` unchanged. The count wraps in two's complement. In up mode, down pulses are ignored.
- R4: Bit 15 shows `up_en` as sampled at the previous edge. Bit 14 shows `dn_en` the same way in bidirectional mode and reads 0 in up mode.
- R5: In up mode, a step that lands `acc` on `hi_preset` sets bit 13 (hit) and bit 12. Bit 13 is set only on that step, never while the count merely stays at or beyond the preset. Bits 11, 9 and 8 read 0 in up mode.
- R6: In bidirectional mode, bit 12 latches a step from +32767 to -32768 and bit 11 latches a step from -32768 to +32767. Bit 13 reads 0 in this mode.
- R7: In bidirectional mode, bit 9 is 1 while `acc` is greater than or equal to `hi_preset` (signed). Bit 8 is 1 while `acc` is less than or equal to `lo_preset` (signed).
- R8: An interrupt event is raised by any of the following, and only while bit 1 is set:
  - an up-mode hit;
  - a bidirectional overflow or underflow;
  - a bidirectional step that makes bit 9 rise;
  - a bidirectional step that makes bit 8 rise.

  An interrupt event sets bit 3 (pending), and `irq` equals bit 3.
- R9: An event that arrives while bit 3 is set and no acknowledge is given in that cycle sets bit 2 (lost). The pending request keeps its original cause.
- R10: `ack_stb` while bit 3 is set clears bit 3. It also writes the cause field bits 7:4 one-hot: overflow = 1000, underflow = 0100, high preset = 0010, low preset = 0001. When several events arrive together, the cause is chosen in that order of priority. An acknowledge while bit 3 is clear changes nothing.
- R11: `clr_hit`, `clr_ovf`, `clr_unf` and `clr_lost` clear bits 13, 12, 11 and 2 respectively. A set in the same cycle wins over the clear.
- R12: `reset_cmd` sets `acc` to 0 and clears bits 13, 12, 11, 3 and 2. It suppresses every event in its cycle.
- R13: `snap_stb` copies `acc` into `snap_acc` at that edge, and bit 10 reads 1 for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_stb | input | 1 | Configure strobe |
| cfg_bidir | input | 1 | Mode loaded by `cfg_stb`: 1 bidirectional, 0 up |
| reset_cmd | input | 1 | Reset/reload command |
| ack_stb | input | 1 | Interrupt acknowledge (servicing starts) |
| clr_hit | input | 1 | Clear bit 13 |
| clr_ovf | input | 1 | Clear bit 12 |
| clr_unf | input | 1 | Clear bit 11 |
| clr_lost | input | 1 | Clear bit 2 |
| snap_stb | input | 1 | Copy accumulator to `snap_acc` |
| up_en | input | 1 | Count-up enable |
| dn_en | input | 1 | Count-down enable |
| up_pulse | input | 1 | Up count pulse, one count per cycle |
| dn_pulse | input | 1 | Down count pulse, one count per cycle |
| hi_preset | input | 16 | High preset, signed |
| lo_preset | input | 16 | Low preset, signed |
| acc | output | 16 | Hardware accumulator, signed |
| snap_acc | output | 16 | Host-visible accumulator copy |
| status | output | 16 | Status and interrupt-cause word |
| irq | output | 1 | Interrupt request (equals bit 3) |

## Verification
The bench drives the count across both two's complement wrap points.

- A design that flagged the wrap from the wrong end, or compared the presets unsigned, would show the wrong overflow or underflow bit, or the wrong live compare bits, at -32768 and +32767.
- At the wrap the overflow event and the low-preset crossing fire in the same cycle. A design with the wrong priority would record the low-preset cause instead of the overflow cause. A design that did not clear the sibling bits would leave two cause bits set.
- A second event is sent while one is pending. A design that dropped the lost bit, or overwrote the pending cause, would show the wrong bit 2 or the wrong cause after the acknowledge.
- The bench also checks the following: clear strobes given in the same cycle as a set; an edge-only hit that must not re-fire; events before the interrupt enable is set; and down pulses in up mode.

// File: rtl/pec_pkg.sv
package pec_pkg;

  // status word bit positions
  localparam int unsigned SB_UP_EN  = 15;
  localparam int unsigned SB_DN_EN  = 14;
  localparam int unsigned SB_HIT    = 13;
  localparam int unsigned SB_OVF    = 12;
  localparam int unsigned SB_UNF    = 11;
  localparam int unsigned SB_SNAP   = 10;
  localparam int unsigned SB_GE_HI  = 9;
  localparam int unsigned SB_LE_LO  = 8;
  localparam int unsigned SB_CAUSE  = 4;   // cause field occupies 7:4
  localparam int unsigned SB_PEND   = 3;
  localparam int unsigned SB_LOST   = 2;
  localparam int unsigned SB_IE     = 1;
  localparam int unsigned NCAUSE    = 4;

  typedef enum logic [1:0] {
    CZ_OVF = 2'd0,
    CZ_UNF = 2'd1,
    CZ_HI  = 2'd2,
    CZ_LO  = 2'd3
  } cause_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic hi;
    logic lo;
  } evt_t;

  // priority: overflow, underflow, high preset, low preset
  function automatic cause_e pick_cause(evt_t e);
    if (e.ovf)      return CZ_OVF;
    else if (e.unf) return CZ_UNF;
    else if (e.hi)  return CZ_HI;
    else            return CZ_LO;
  endfunction

  // one-hot encoding for the cause field, MSB = overflow
  function automatic logic [NCAUSE-1:0] cause_onehot(cause_e c);
    logic [NCAUSE-1:0] v;
    v = '0;
    v[NCAUSE-1-int'(c)] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/pec_accum.sv
module pec_accum #(
  parameter int unsigned W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bidir,
  input  logic                reset_cmd,
  input  logic                up_en,
  input  logic                dn_en,
  input  logic                up_pulse,
  input  logic                dn_pulse,
  input  logic signed [W-1:0] hi_preset,
  input  logic signed [W-1:0] lo_preset,
  output logic signed [W-1:0] acc,
  output logic                ge_hi,
  output logic                le_lo,
  output logic                hit_evt,
  output logic                ovf_evt,
  output logic                unf_evt,
  output logic                hi_cross,
  output logic                lo_cross
);

  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic inc, dec, mv_up, mv_dn, moved;
  logic signed [W-1:0] acc_nxt;
  logic ge_nxt, le_nxt;

  assign inc   = up_en & up_pulse;
  assign dec   = bidir & dn_en & dn_pulse;
  assign mv_up = inc & ~dec;
  assign mv_dn = dec & ~inc;
  assign moved = mv_up | mv_dn;

  always_comb begin
    if (mv_up)      acc_nxt = acc + ONE;
    else if (mv_dn) acc_nxt = acc - ONE;
    else            acc_nxt = acc;
  end

  // live compares on the current and the next value
  assign ge_hi  = (acc >= hi_preset);
  assign le_lo  = (acc <= lo_preset);
  assign ge_nxt = (acc_nxt >= hi_preset);
  assign le_nxt = (acc_nxt <= lo_preset);

  // events are suppressed while the reset command is active
  assign hit_evt  = ~reset_cmd & ~bidir & mv_up & (acc_nxt == hi_preset);
  assign ovf_evt  = ~reset_cmd &  bidir & mv_up & (acc == MAXV);
  assign unf_evt  = ~reset_cmd &  bidir & mv_dn & (acc == MINV);
  assign hi_cross = ~reset_cmd &  bidir & moved & ge_nxt & ~ge_hi;
  assign lo_cross = ~reset_cmd &  bidir & moved & le_nxt & ~le_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc <= '0;
    else if (reset_cmd) acc <= '0;
    else                acc <= acc_nxt;
  end

endmodule

// File: rtl/pec_irq.sv
module pec_irq
  import pec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_stb,
  input  logic              reset_cmd,
  input  logic              ack_stb,
  input  logic              clr_lost,
  input  evt_t              evt,
  output logic              ie,
  output logic              pend,
  output logic              lost,
  output logic [NCAUSE-1:0] cause
);

  cause_e pcause;
  logic   evt_any, serviced, lost_set;

  assign evt_any  = (|evt) & ie;
  assign serviced = ack_stb & pend;
  assign lost_set = evt_any & pend & ~ack_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie     <= 1'b0;
      pend   <= 1'b0;
      lost   <= 1'b0;
      cause  <= '0;
      pcause <= CZ_OVF;
    end else if (cfg_stb) begin
      ie    <= 1'b1;
      pend  <= 1'b0;
      cause <= '0;
    end else if (reset_cmd) begin
      pend <= 1'b0;
      lost <= 1'b0;
    end else begin
      if (serviced) cause <= cause_onehot(pcause);

      if (evt_any) begin
        pend <= 1'b1;
        // first event of a pending request keeps its cause
        if (!pend || ack_stb) pcause <= pick_cause(evt);
      end else if (ack_stb) begin
        pend <= 1'b0;
      end

      if (lost_set)      lost <= 1'b1;
      else if (clr_lost) lost <= 1'b0;
    end
  end

endmodule

// File: rtl/pec_status.sv
module pec_status
  import pec_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_stb,
  input  logic                cfg_bidir,
  input  logic                reset_cmd,
  input  logic                up_en,
  input  logic                dn_en,
  input  logic                clr_hit,
  input  logic                clr_ovf,
  input  logic                clr_unf,
  input  logic                snap_stb,
  input  logic signed [W-1:0] acc,
  input  logic                ge_hi,
  input  logic                le_lo,
  input  logic                hit_evt,
  input  logic                ovf_evt,
  input  logic                unf_evt,
  input  logic                ie,
  input  logic                pend,
  input  logic                lost,
  input  logic [NCAUSE-1:0]   cause,
  output logic                bidir,
  output logic signed [W-1:0] snap_acc,
  output logic [15:0]         status
);

  logic up_q, dn_q, hit_q, ovf_q, unf_q, snap_q;

  // mode and enable mirrors
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bidir <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else if (cfg_stb) begin
      bidir <= cfg_bidir;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      up_q <= up_en;
      dn_q <= dn_en;
    end
  end

  // latched flags: set has priority over the host clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (reset_cmd) begin
      hit_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (hit_evt)      hit_q <= 1'b1;
      else if (clr_hit) hit_q <= 1'b0;
      if (hit_evt || ovf_evt) ovf_q <= 1'b1;
      else if (clr_ovf)       ovf_q <= 1'b0;
      if (unf_evt)      unf_q <= 1'b1;
      else if (clr_unf) unf_q <= 1'b0;
    end
  end

  // snapshot register and one-cycle update flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_acc <= '0;
      snap_q   <= 1'b0;
    end else begin
      snap_q <= snap_stb;
      if (snap_stb) snap_acc <= acc;
    end
  end

  always_comb begin
    status                           = '0;
    status[SB_UP_EN]                 = up_q;
    status[SB_DN_EN]                 = dn_q & bidir;
    status[SB_HIT]                   = hit_q & ~bidir;
    status[SB_OVF]                   = ovf_q;
    status[SB_UNF]                   = unf_q & bidir;
    status[SB_SNAP]                  = snap_q;
    status[SB_GE_HI]                 = ge_hi & bidir;
    status[SB_LE_LO]                 = le_lo & bidir;
    status[SB_CAUSE+:NCAUSE]         = cause;
    status[SB_PEND]                  = pend;
    status[SB_LOST]                  = lost;
    status[SB_IE]                    = ie;
  end

endmodule

// File: rtl/preset_event_counter.sv
module preset_event_counter
  import pec_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_stb,
  input  logic                cfg_bidir,
  input  logic                reset_cmd,
  input  logic                ack_stb,
  input  logic                clr_hit,
  input  logic                clr_ovf,
  input  logic                clr_unf,
  input  logic                clr_lost,
  input  logic                snap_stb,
  input  logic                up_en,
  input  logic                dn_en,
  input  logic                up_pulse,
  input  logic                dn_pulse,
  input  logic signed [W-1:0] hi_preset,
  input  logic signed [W-1:0] lo_preset,
  output logic signed [W-1:0] acc,
  output logic signed [W-1:0] snap_acc,
  output logic [15:0]         status,
  output logic                irq
);

  logic bidir, ge_hi, le_lo;
  logic hit_evt, ovf_evt, unf_evt, hi_cross, lo_cross;
  logic ie, pend, lost;
  logic [NCAUSE-1:0] cause;
  evt_t evt;

  pec_accum #(.W(W)) u_accum (
    .clk(clk), .rst_n(rst_n), .bidir(bidir), .reset_cmd(reset_cmd),
    .up_en(up_en), .dn_en(dn_en), .up_pulse(up_pulse), .dn_pulse(dn_pulse),
    .hi_preset(hi_preset), .lo_preset(lo_preset), .acc(acc),
    .ge_hi(ge_hi), .le_lo(le_lo), .hit_evt(hit_evt), .ovf_evt(ovf_evt),
    .unf_evt(unf_evt), .hi_cross(hi_cross), .lo_cross(lo_cross)
  );

  assign evt.ovf = ovf_evt;
  assign evt.unf = unf_evt;
  assign evt.hi  = hit_evt | hi_cross;
  assign evt.lo  = lo_cross;

  pec_irq u_irq (
    .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .reset_cmd(reset_cmd),
    .ack_stb(ack_stb), .clr_lost(clr_lost), .evt(evt),
    .ie(ie), .pend(pend), .lost(lost), .cause(cause)
  );

  pec_status #(.W(W)) u_status (
    .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_bidir(cfg_bidir),
    .reset_cmd(reset_cmd), .up_en(up_en), .dn_en(dn_en),
    .clr_hit(clr_hit), .clr_ovf(clr_ovf), .clr_unf(clr_unf),
    .snap_stb(snap_stb), .acc(acc), .ge_hi(ge_hi), .le_lo(le_lo),
    .hit_evt(hit_evt), .ovf_evt(ovf_evt), .unf_evt(unf_evt),
    .ie(ie), .pend(pend), .lost(lost), .cause(cause),
    .bidir(bidir), .snap_acc(snap_acc), .status(status)
  );

  assign irq = pend;

endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int unsigned W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_stb,
  input logic                reset_cmd,
  input logic                snap_stb,
  input logic signed [W-1:0] acc,
  input logic signed [W-1:0] snap_acc,
  input logic [15:0]         status,
  input logic                irq
);

  AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] == 1'b0); // R1

  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_stb |=> status[1] && status[7:3] == 5'd0 && status[15:14] == 2'd0); // R2

  AST_HIT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    status[13] |-> !status[11] && !status[9] && !status[8]); // R5

  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq == status[3]); // R8

  AST_LOST_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(status[3])); // R9

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status[7:4])); // R10

  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd && !cfg_stb |=> acc == '0 && status[13:11] == 3'd0 && status[3:2] == 2'd0); // R12

  AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    snap_stb |=> status[10] && snap_acc == $past(acc)); // R13

endmodule

bind preset_event_counter pec_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .reset_cmd(reset_cmd),
  .snap_stb(snap_stb), .acc(acc), .snap_acc(snap_acc), .status(status),
  .irq(irq)
);

// File: tb/preset_event_counter_bench.sv
`timescale 1ns/1ps
module preset_event_counter_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_stb = 0, cfg_bidir = 0, reset_cmd = 0, ack_stb = 0;
  logic clr_hit = 0, clr_ovf = 0, clr_unf = 0, clr_lost = 0, snap_stb = 0;
  logic up_en = 0, dn_en = 0, up_pulse = 0, dn_pulse = 0;
  logic signed [15:0] hi_preset = 16'sd1, lo_preset = -16'sd2;
  logic signed [15:0] acc, snap_acc;
  logic [15:0] status;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  preset_event_counter u_preset_event_counter (
    .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_bidir(cfg_bidir),
    .reset_cmd(reset_cmd), .ack_stb(ack_stb), .clr_hit(clr_hit),
    .clr_ovf(clr_ovf), .clr_unf(clr_unf), .clr_lost(clr_lost),
    .snap_stb(snap_stb), .up_en(up_en), .dn_en(dn_en),
    .up_pulse(up_pulse), .dn_pulse(dn_pulse), .hi_preset(hi_preset),
    .lo_preset(lo_preset), .acc(acc), .snap_acc(snap_acc),
    .status(status), .irq(irq)
  );

  typedef struct packed {
    logic        up;
    logic        dn;
    logic        ge;
    logic        le;
    logic [15:0] acc;
  } vec_t;

  // bidirectional walk, hi = 3, lo = -2, starting at 0
  localparam vec_t VEC [0:11] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0001},
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0002},
    '{1'b1, 1'b0, 1'b1, 1'b0, 16'h0003},
    '{1'b1, 1'b1, 1'b1, 1'b0, 16'h0003},
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0002},
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0001},
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF},
    '{1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFE},
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'hFFFE},
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF},
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_strobes();
    cfg_stb = 0; reset_cmd = 0; ack_stb = 0; clr_hit = 0; clr_ovf = 0;
    clr_unf = 0; clr_lost = 0; snap_stb = 0; up_pulse = 0; dn_pulse = 0;
  endtask

  task automatic do_cfg(input logic bd, input logic signed [15:0] hi);
    cfg_bidir = bd; hi_preset = hi; cfg_stb = 1; tick(); clear_strobes();
  endtask

  task automatic do_rcmd(); reset_cmd = 1; tick(); clear_strobes(); endtask
  task automatic do_ack();  ack_stb = 1;   tick(); clear_strobes(); endtask
  task automatic do_up();   up_pulse = 1;  tick(); clear_strobes(); endtask
  task automatic do_dn();   dn_pulse = 1;  tick(); clear_strobes(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk(status == 16'h0000, "R1 status", status, 0);
    chk(acc == 0 && snap_acc == 0, "R1 acc", acc, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);

    // R8 no interrupt before enable; R5 up-mode hit
    up_en = 1; do_up();
    chk(acc == 16'sd1, "R3 up count", acc, 1);
    chk(status[13] && status[12], "R5 hit latch", status, 16'h3000);
    chk(irq == 1'b0 && status[3] == 1'b0, "R8 gated by enable", irq, 0);
    chk(status[15] == 1'b1, "R4 up mirror", status, 16'h8000);

    // R2 configure bidirectional
    dn_en = 1; do_cfg(1'b1, 16'sd3);
    chk(status[1] && status[15:14] == 2'b00 && status[7:3] == 0, "R2 cfg clears", status, 16'h0002);
    chk(status[12] == 1'b1 && status[13] == 1'b0, "R6 latch kept, hit reserved", status, 16'h1000);
    do_rcmd();
    chk(acc == 0 && status[13:11] == 0 && status[3:2] == 0, "R12 reset cmd", status, 0);
    chk(status[15:14] == 2'b11, "R4 mirrors", status, 16'hC000);

    // R3 R7 vector walk
    foreach (VEC[i]) begin
      up_pulse = VEC[i].up; dn_pulse = VEC[i].dn;
      tick(); clear_strobes();
      chk(acc == VEC[i].acc, "R3 walk acc", acc, VEC[i].acc);
      chk(status[9] == VEC[i].ge && status[8] == VEC[i].le, "R7 compare", status[9:8], {VEC[i].ge, VEC[i].le});
    end
    chk(irq && status[3], "R8 pending", status, 16'h0008);
    chk(status[2] == 1'b1, "R9 lost", status, 16'h0004);
    do_ack();
    chk(status[7:4] == 4'b0010 && !status[3], "R10 cause hi", status[7:3], 5'b00100);
    do_ack();
    chk(status[7:4] == 4'b0010, "R10 ack without pending", status[7:4], 4'b0010);
    clr_lost = 1; tick(); clear_strobes();
    chk(status[2] == 1'b0, "R11 clear lost", status, 0);

    // wrap points
    do_rcmd();
    up_pulse = 1; repeat (32767) tick(); clear_strobes();
    chk(acc == 16'sh7FFF, "R3 count to max", acc, 16'h7FFF);
    ack_stb = 1; clr_lost = 1; tick(); clear_strobes();
    chk(!irq && !status[2], "R10 ack before wrap", status, 0);
    do_up();
    chk(acc == -16'sd32768, "R3 wrap up", acc, 16'h8000);
    chk(status[12] && irq, "R6 overflow latch", status, 16'h1008);
    do_ack();
    chk(status[7:4] == 4'b1000, "R10 cause ovf", status[7:4], 4'b1000);
    do_dn();
    chk(acc == 16'sh7FFF, "R3 wrap down", acc, 16'h7FFF);
    chk(status[11] && irq, "R6 underflow latch", status, 16'h0808);
    do_ack();
    chk(status[7:4] == 4'b0100, "R10 cause unf", status[7:4], 4'b0100);

    // R11 clears and set-over-clear
    clr_ovf = 1; tick(); clear_strobes();
    chk(status[12] == 1'b0, "R11 clear ovf", status, 0);
    up_pulse = 1; clr_ovf = 1; tick(); clear_strobes();
    chk(status[12] == 1'b1, "R11 set wins", status, 16'h1000);
    clr_unf = 1; tick(); clear_strobes();
    chk(status[11] == 1'b0, "R11 clear unf", status, 0);

    // R13 snapshot
    snap_stb = 1; tick(); clear_strobes();
    chk(snap_acc == -16'sd32768 && status[10], "R13 snapshot", snap_acc, 16'h8000);
    tick();
    chk(status[10] == 1'b0 && snap_acc == -16'sd32768, "R13 flag one cycle", status, 0);

    // up mode
    do_rcmd();
    do_cfg(1'b0, 16'sd5);
    chk(status[7:4] == 4'b0000 && status[1], "R2 cfg clears cause", status[7:4], 0);
    repeat (5) do_up();
    chk(acc == 16'sd5 && status[13] && status[12] && irq, "R5 up hit", status, 16'h3008);
    chk(status[11] == 0 && status[9:8] == 0 && status[14] == 0, "R5 R4 reserved in up mode", status, 16'h0000);
    do_dn();
    chk(acc == 16'sd5, "R3 down ignored in up mode", acc, 5);
    clr_hit = 1; tick(); clear_strobes();
    chk(!status[13] && status[12], "R11 clear hit", status, 16'h1000);
    do_up();
    chk(acc == 16'sd6 && !status[13], "R5 edge only", status, 0);

    // R12 reset wins over event
    hi_preset = 16'sd1; reset_cmd = 1; up_pulse = 1; tick(); clear_strobes();
    chk(acc == 0 && !irq && !status[13], "R12 reset wins", acc, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule